// File: doc/BRIEF.md
# PCM Voice Slot Serializer / Deserializer

This block moves one voice sample per frame across a serial PCM line. A separate clock generator supplies single-cycle strobes for the rising and falling edges of the bit clock. It also supplies a frame-start strobe and a bit counter that gives the bit's position within the frame. The first 16 bits of each frame form the single active slot. Frames must be at least 32 bits long, so the slot that follows the active one is never active.

On transmit, the block places an 8-bit or 13-bit sample into the 16-bit slot and shifts it out in the selected bit order. It can fill the spare bits as padding, with the 3-bit gain value or with zeros. It can instead extend the sample's sign. A mute control forces the data line low. An output-enable signal tells the pad when to release the line after the slot, at one of two selectable points. On receive, the block collects the 16 slot bits, undoes the formatting and presents the sample with a one-cycle valid strobe.

Top module: `pcm_slot_codec`

## Requirements
- R1: The active slot is frame bits 0 to 15. On each `bit_rise` strobe with bit counter b < 16, `tx_dout` takes slot bit b one cycle later. On a `bit_rise` with b >= 16, the data register returns to 0.
- R2: In padding mode (`cfg_sext`=0) with 13-bit samples (`cfg_w8`=0), slot[15:3] carries the sample and slot[2:0] carries `tx_gain`.
- R3: In padding mode with 8-bit samples (`cfg_w8`=1), slot[15:8] carries `tx_sample[7:0]` and slot[7:0] is zero.
- R4: In sign-extension mode (`cfg_sext`=1), the sample sits in the low 13 bits (or 8 bits), and every bit above it copies the sample's top bit.
- R5: With `cfg_lsb_first`=0, the slot travels MSB first: step b carries slot[15-b]. With `cfg_lsb_first`=1, step b carries slot[b]. The same order applies on transmit and on receive.
- R6: Sample and gain are captured on `frame_start`. A change of `tx_sample` later in the frame does not alter the slot being sent.
- R7: With `cfg_tri_en`=1 and `cfg_tri_late`=0, `tx_oe` is high from the first slot bit onward. It drops one cycle after the `bit_fall` strobe of bit 15.
- R8: With `cfg_tri_en`=1 and `cfg_tri_late`=1, `tx_oe` stays high through the fall of bit 15. It drops one cycle after the `bit_rise` strobe of bit 16.
- R9: With `cfg_tri_en`=0, `tx_oe` is 1 at all times.
- R10: With `cfg_mute`=1, `tx_dout` is 0 whatever the sample. Output-enable timing is unchanged.
- R11: `rx_din` is sampled on each `bit_fall` with b < 16. One cycle after the fall of bit 15, `rx_valid` pulses for exactly one cycle, and `rx_sample` holds the extracted value. Padding mode takes slot[15:3] (13-bit) or slot[15:8] (8-bit). Sign-extension mode takes slot[12:0] or slot[7:0]. Any unused upper bits of `rx_sample` are zero.
- R12: After reset, `tx_dout`=0, `rx_valid`=0 and `rx_sample`=0. `tx_oe`=0 when `cfg_tri_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_rise | input | 1 | Bit-clock rising-edge strobe |
| bit_fall | input | 1 | Bit-clock falling-edge strobe |
| frame_start | input | 1 | Frame start, given with the `bit_rise` of bit 0 |
| bit_cnt | input | CNT_W | Bit position in the frame |
| cfg_w8 | input | 1 | 1 = 8-bit samples, 0 = 13-bit samples |
| cfg_sext | input | 1 | 1 = sign extension, 0 = padding |
| cfg_lsb_first | input | 1 | 1 = LSB first |
| cfg_tri_en | input | 1 | Release the output after the slot |
| cfg_tri_late | input | 1 | Release on the next rise instead of the last fall |
| cfg_mute | input | 1 | Force transmit data to 0 |
| tx_sample | input | 13 | Transmit sample |
| tx_gain | input | 3 | Gain bits used for 13-bit padding |
| rx_din | input | 1 | Serial receive data |
| tx_dout | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Pad output enable |
| rx_sample | output | 13 | Received sample |
| rx_valid | output | 1 | One-cycle strobe, received sample ready |

## Verification
The transmit path is driven with a negative 13-bit sample, a positive 8-bit sample and a negative 8-bit sample, in each of the four format modes. The values are chosen so that gain bits, zero fill and sign copies each leave a distinct 16-bit pattern. An asymmetric word is sent in both bit orders, which separates a reversed order from a correct one on both paths. The receive path gets slot words whose discarded bits are deliberately non-zero, so that extracting the wrong field shows up. Separate frames change the sample mid-slot, mute the output, and walk the output enable through its three settings, so each release point is seen on its own edge.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;
  localparam int SLOT_BITS = 16;
  localparam int SAMPLE_W  = 13;
  localparam int GAIN_W    = 3;
  localparam int POS_W     = $clog2(SLOT_BITS);

  // Place a sample into a 16-bit slot.
  function automatic logic [SLOT_BITS-1:0] slot_format(
    input logic [SAMPLE_W-1:0] smp,
    input logic [GAIN_W-1:0]   gain,
    input logic                w8,
    input logic                sext);
    logic [SLOT_BITS-1:0] w;
    case ({sext, w8})
      2'b00:   w = {smp, gain};
      2'b01:   w = {smp[7:0], 8'h00};
      2'b10:   w = {{(SLOT_BITS-SAMPLE_W){smp[SAMPLE_W-1]}}, smp};
      default: w = {{8{smp[7]}}, smp[7:0]};
    endcase
    return w;
  endfunction

  // Recover a sample from a 16-bit slot.
  function automatic logic [SAMPLE_W-1:0] slot_extract(
    input logic [SLOT_BITS-1:0] w,
    input logic                 w8,
    input logic                 sext);
    logic [SAMPLE_W-1:0] s;
    case ({sext, w8})
      2'b00:   s = w[SLOT_BITS-1 -: SAMPLE_W];
      2'b01:   s = {5'b0, w[15:8]};
      2'b10:   s = w[SAMPLE_W-1:0];
      default: s = {5'b0, w[7:0]};
    endcase
    return s;
  endfunction

  // Slot bit index carried at serial step b.
  function automatic logic [POS_W-1:0] slot_pos(
    input logic [POS_W-1:0] step,
    input logic             lsb_first);
    return lsb_first ? step : POS_W'(SLOT_BITS-1) - step;
  endfunction
endpackage

// File: rtl/pcm_slot_tx.sv
module pcm_slot_tx
  import pcm_slot_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_rise,
  input  logic                bit_fall,
  input  logic                frame_start,
  input  logic [CNT_W-1:0]    bit_cnt,
  input  logic                cfg_w8,
  input  logic                cfg_sext,
  input  logic                cfg_lsb_first,
  input  logic                cfg_tri_late,
  input  logic [SAMPLE_W-1:0] tx_sample,
  input  logic [GAIN_W-1:0]   tx_gain,
  output logic                dout_q,
  output logic                oe_q,
  output logic                in_slot,
  output logic                last_fall
);
  logic [SLOT_BITS-1:0] word_q;
  logic [SLOT_BITS-1:0] word_now;
  logic [POS_W-1:0]     pos;

  assign in_slot   = bit_cnt < CNT_W'(SLOT_BITS);
  assign last_fall = bit_fall && (bit_cnt == CNT_W'(SLOT_BITS-1));
  assign pos       = slot_pos(bit_cnt[POS_W-1:0], cfg_lsb_first);
  assign word_now  = frame_start ? slot_format(tx_sample, tx_gain, cfg_w8, cfg_sext)
                                 : word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      dout_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      if (frame_start) word_q <= word_now;
      if (bit_rise) begin
        if (in_slot) begin
          dout_q <= word_now[pos];
          oe_q   <= 1'b1;
        end else begin
          dout_q <= 1'b0;
          oe_q   <= 1'b0;
        end
      end else if (last_fall && !cfg_tri_late) begin
        oe_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pcm_slot_rx.sv
module pcm_slot_rx
  import pcm_slot_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_fall,
  input  logic [CNT_W-1:0]    bit_cnt,
  input  logic                cfg_w8,
  input  logic                cfg_sext,
  input  logic                cfg_lsb_first,
  input  logic                rx_din,
  output logic [SAMPLE_W-1:0] rx_sample,
  output logic                rx_valid
);
  logic [SLOT_BITS-1:0] shf_q;
  logic [SLOT_BITS-1:0] shf_now;
  logic [POS_W-1:0]     pos;
  logic                 cap;
  logic                 done;

  assign pos  = slot_pos(bit_cnt[POS_W-1:0], cfg_lsb_first);
  assign cap  = bit_fall && (bit_cnt < CNT_W'(SLOT_BITS));
  assign done = bit_fall && (bit_cnt == CNT_W'(SLOT_BITS-1));

  always_comb begin
    shf_now      = shf_q;
    shf_now[pos] = rx_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shf_q     <= '0;
      rx_sample <= '0;
      rx_valid  <= 1'b0;
    end else begin
      rx_valid <= done;
      if (cap)  shf_q     <= shf_now;
      if (done) rx_sample <= slot_extract(shf_now, cfg_w8, cfg_sext);
    end
  end
endmodule

// File: rtl/pcm_slot_codec.sv
module pcm_slot_codec
  import pcm_slot_pkg::*;
#(
  parameter int FRAME_BITS = 32,
  localparam int CNT_W     = $clog2(FRAME_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_rise,
  input  logic                bit_fall,
  input  logic                frame_start,
  input  logic [CNT_W-1:0]    bit_cnt,
  input  logic                cfg_w8,
  input  logic                cfg_sext,
  input  logic                cfg_lsb_first,
  input  logic                cfg_tri_en,
  input  logic                cfg_tri_late,
  input  logic                cfg_mute,
  input  logic [SAMPLE_W-1:0] tx_sample,
  input  logic [GAIN_W-1:0]   tx_gain,
  input  logic                rx_din,
  output logic                tx_dout,
  output logic                tx_oe,
  output logic [SAMPLE_W-1:0] rx_sample,
  output logic                rx_valid
);
  logic dout_q;
  logic oe_q;
  logic in_slot;
  logic last_fall;

  pcm_slot_tx #(.CNT_W(CNT_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .bit_rise(bit_rise), .bit_fall(bit_fall),
    .frame_start(frame_start), .bit_cnt(bit_cnt), .cfg_w8(cfg_w8),
    .cfg_sext(cfg_sext), .cfg_lsb_first(cfg_lsb_first),
    .cfg_tri_late(cfg_tri_late), .tx_sample(tx_sample), .tx_gain(tx_gain),
    .dout_q(dout_q), .oe_q(oe_q), .in_slot(in_slot), .last_fall(last_fall)
  );

  pcm_slot_rx #(.CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .bit_fall(bit_fall), .bit_cnt(bit_cnt),
    .cfg_w8(cfg_w8), .cfg_sext(cfg_sext), .cfg_lsb_first(cfg_lsb_first),
    .rx_din(rx_din), .rx_sample(rx_sample), .rx_valid(rx_valid)
  );

  assign tx_dout = cfg_mute ? 1'b0 : dout_q;
  assign tx_oe   = oe_q | ~cfg_tri_en;
endmodule

// File: rtl/pcm_slot_codec_chk.sv
module pcm_slot_codec_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_rise,
  input logic             bit_fall,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             cfg_tri_en,
  input logic             cfg_tri_late,
  input logic             cfg_mute,
  input logic             tx_dout,
  input logic             tx_oe,
  input logic             rx_valid,
  input logic             in_slot,
  input logic             last_fall
);
  p_mute_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mute |-> !tx_dout);

  p_no_tri_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_tri_en |-> tx_oe);

  p_oe_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_rise && in_slot) |=> tx_oe);

  p_early_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (last_fall && cfg_tri_en && !cfg_tri_late) |=> !tx_oe);

  p_late_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (last_fall && cfg_tri_en && cfg_tri_late) |=> tx_oe);

  p_late_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_rise && !in_slot && cfg_tri_en) |=> !tx_oe);

  p_valid_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(bit_fall && bit_cnt == CNT_W'(15)));

  p_valid_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
endmodule

bind pcm_slot_codec pcm_slot_codec_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_rise(bit_rise), .bit_fall(bit_fall),
  .bit_cnt(bit_cnt), .cfg_tri_en(cfg_tri_en), .cfg_tri_late(cfg_tri_late),
  .cfg_mute(cfg_mute), .tx_dout(tx_dout), .tx_oe(tx_oe), .rx_valid(rx_valid),
  .in_slot(in_slot), .last_fall(last_fall)
);

// File: tb/pcm_slot_codec_bench.sv
module pcm_slot_codec_bench;
  localparam int FB = 32;
  localparam int CW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_rise = 0, bit_fall = 0, frame_start = 0;
  logic [CW-1:0] bit_cnt = '0;
  logic cfg_w8 = 0, cfg_sext = 0, cfg_lsb_first = 0;
  logic cfg_tri_en = 1, cfg_tri_late = 0, cfg_mute = 0;
  logic [12:0] tx_sample = '0;
  logic [2:0]  tx_gain = '0;
  logic rx_din = 0;
  logic tx_dout, tx_oe, rx_valid;
  logic [12:0] rx_sample;

  int n_chk = 0, n_bad = 0;
  logic [15:0] got_word;
  logic        tail_zero;
  logic        oe_r [FB];
  logic        oe_f [FB];
  int          vcount;
  logic [12:0] vsample;

  always #2 clk = ~clk;

  pcm_slot_codec #(.FRAME_BITS(FB)) u_pcm_slot_codec (
    .clk(clk), .rst_n(rst_n), .bit_rise(bit_rise), .bit_fall(bit_fall),
    .frame_start(frame_start), .bit_cnt(bit_cnt), .cfg_w8(cfg_w8),
    .cfg_sext(cfg_sext), .cfg_lsb_first(cfg_lsb_first), .cfg_tri_en(cfg_tri_en),
    .cfg_tri_late(cfg_tri_late), .cfg_mute(cfg_mute), .tx_sample(tx_sample),
    .tx_gain(tx_gain), .rx_din(rx_din), .tx_dout(tx_dout), .tx_oe(tx_oe),
    .rx_sample(rx_sample), .rx_valid(rx_valid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // Expected slot, computed arithmetically from the requirements.
  function automatic logic [15:0] expect_slot(input logic [12:0] s, input logic [2:0] g,
                                              input logic w8, input logic sx);
    int v;
    if (!sx && !w8) return 16'(int'(s) * 8 + int'(g));
    if (!sx &&  w8) return 16'(int'(s % 256) * 256);
    if (!w8) begin v = int'(s); if (v >= 4096) v = v - 8192; end
    else begin v = int'(s % 256); if (v >= 128) v = v - 256; end
    return 16'(v);
  endfunction

  // One full frame: bit period of four system cycles.
  task automatic run_frame(input logic [15:0] rx_word, input int chg_at,
                           input logic [12:0] chg_val);
    int p;
    got_word = '0; tail_zero = 1; vcount = 0; vsample = '0;
    for (int b = 0; b < FB; b++) begin
      @(negedge clk);
      bit_rise = 1; bit_cnt = CW'(b); frame_start = (b == 0);
      p = cfg_lsb_first ? b : 15 - b;
      if (b < 16) rx_din = rx_word[p];
      if (b == chg_at) tx_sample = chg_val;
      @(negedge clk);
      bit_rise = 0; frame_start = 0;
      oe_r[b] = tx_oe;
      if (b < 16) got_word[p] = tx_dout; else if (tx_dout !== 1'b0) tail_zero = 0;
      if (rx_valid) begin vcount++; vsample = rx_sample; end
      @(negedge clk);
      bit_fall = 1;
      if (rx_valid) begin vcount++; vsample = rx_sample; end
      @(negedge clk);
      bit_fall = 0;
      oe_f[b] = tx_oe;
      if (rx_valid) begin vcount++; vsample = rx_sample; end
    end
  endtask

  task automatic set_cfg(input logic w8, input logic sx, input logic lsb);
    cfg_w8 = w8; cfg_sext = sx; cfg_lsb_first = lsb;
  endtask

  task automatic t_reset();
    chk("R12 tx_dout", tx_dout, 0);
    chk("R12 tx_oe", tx_oe, 0);
    chk("R12 rx_valid", rx_valid, 0);
    chk("R12 rx_sample", rx_sample, 0);
  endtask

  task automatic t_format(input logic w8, input logic sx, input logic [12:0] s,
                          input logic [2:0] g, input string req);
    set_cfg(w8, sx, 0); tx_sample = s; tx_gain = g;
    run_frame(16'h0, -1, '0);
    chk(req, got_word, expect_slot(s, g, w8, sx));
    chk("R1 idle bits zero", tail_zero, 1);
  endtask

  task automatic t_rx(input logic w8, input logic sx, input logic lsb,
                      input logic [15:0] w, input logic [12:0] exp, input string req);
    set_cfg(w8, sx, lsb);
    run_frame(w, -1, '0);
    chk("R11 one valid pulse", vcount, 1);
    chk(req, vsample, exp);
  endtask

  task automatic t_order();
    set_cfg(0, 0, 1); tx_sample = 13'h0B29; tx_gain = 3'd6;
    run_frame(16'h0, -1, '0);
    chk("R5 lsb-first tx", got_word, expect_slot(13'h0B29, 3'd6, 0, 0));
  endtask

  task automatic t_latch();
    set_cfg(0, 0, 0); tx_sample = 13'h1555; tx_gain = 3'd2;
    run_frame(16'h0, 5, 13'h0AAA);
    chk("R6 mid-slot update ignored", got_word, expect_slot(13'h1555, 3'd2, 0, 0));
  endtask

  task automatic t_tri_early();
    cfg_tri_en = 1; cfg_tri_late = 0; set_cfg(0, 0, 0);
    run_frame(16'h0, -1, '0);
    chk("R7 oe on at bit 0", oe_r[0], 1);
    chk("R7 oe on at fall of bit 14", oe_f[14], 1);
    chk("R7 oe off after fall of bit 15", oe_f[15], 0);
    chk("R7 oe off in idle", oe_r[20], 0);
  endtask

  task automatic t_tri_late();
    cfg_tri_en = 1; cfg_tri_late = 1;
    run_frame(16'h0, -1, '0);
    chk("R8 oe held after fall of bit 15", oe_f[15], 1);
    chk("R8 oe off after rise of bit 16", oe_r[16], 0);
    cfg_tri_late = 0;
  endtask

  task automatic t_no_tri();
    cfg_tri_en = 0;
    run_frame(16'h0, -1, '0);
    chk("R9 oe idle", oe_r[20], 1);
    chk("R9 oe after last fall", oe_f[15], 1);
    cfg_tri_en = 1;
  endtask

  task automatic t_mute();
    set_cfg(0, 0, 0); tx_sample = 13'h1FFF; tx_gain = 3'd7; cfg_mute = 1;
    run_frame(16'h0, -1, '0);
    chk("R10 muted slot", got_word, 0);
    chk("R10 oe unchanged", oe_r[3], 1);
    cfg_mute = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_format(0, 0, 13'h1A35, 3'd5, "R2 pad13 with gain");
    t_format(1, 0, 13'h1FC3, 3'd7, "R3 pad8 zero fill");
    t_format(0, 1, 13'h1234, 3'd1, "R4 sext13 negative");
    t_format(1, 1, 13'h005A, 3'd0, "R4 sext8 positive");
    t_format(1, 1, 13'h1E9A, 3'd3, "R4 sext8 negative");
    t_order();
    t_latch();
    t_rx(0, 0, 0, 16'hD1AF, 13'h1A35, "R11 pad13 rx");
    t_rx(1, 0, 0, 16'hA5FF, 13'h00A5, "R11 pad8 rx");
    t_rx(0, 1, 0, 16'hF234, 13'h1234, "R11 sext13 rx");
    t_rx(1, 1, 0, 16'h779A, 13'h009A, "R11 sext8 rx");
    t_rx(0, 0, 1, 16'h8C71, 13'h118E, "R5 lsb-first rx");
    t_tri_early();
    t_tri_late();
    t_no_tri();
    t_mute();
    report();
  end
endmodule